// File: doc/BRIEF.md
# Split-Byte General Register File

This block is the operand store of a 16-bit processor core. It holds eight word registers. Four of them are general registers: accumulator, count, data and base. Each of these can be handled as one word or as two independent bytes that alias the word. The other four are word-only pointer and index registers: stack pointer, base pointer, source index and destination index. The decode stage reaches the file through two read ports and one write port. Each port takes a 3-bit register code and a byte/word select. Byte reads come back zero-extended to the full word.

A side input decrements the count register for loop instructions. In the same cycle it reports whether the decremented value will be zero. The flags register is never involved. A normal write to the count register in the same cycle takes priority over the decrement. Writes land at the clock edge. A read in the cycle of a write therefore returns the value held before the write. Reset is synchronous and clears every register.

Top module: `split_regfile`

## Requirements
- R1: While the synchronous reset is high at a clock edge, all eight registers become zero. After that edge every word read returns 0.
- R2: In word mode, codes 0 to 7 select accumulator, count, data, base, stack pointer, base pointer, source index and destination index, in that order. A word write stores the full 16-bit write data at the clock edge.
- R3: In byte mode, codes 0 to 3 select the low byte (bits 7:0) of accumulator, count, data and base. Codes 4 to 7 select the high byte (bits 15:8) of the same four registers. A byte write stores write data bits 7:0 into the selected byte and leaves the other byte of that register unchanged.
- R4: A byte read returns the selected byte in bits 7:0 and zero in bits 15:8.
- R5: The pointer and index registers have no byte access. No byte write, whatever its code, changes them.
- R6: A read of a register that is being written in the same cycle returns its value from before the write.
- R7: The two read ports are independent. Each returns its own register and size in the same cycle.
- R8: When the loop input is high at a clock edge, the count register becomes its value minus 1, wrapping from 0 to 0xFFFF. In the same cycle, the zero output is high exactly when the count register holds 1. The zero output is low whenever the loop input is low.
- R9: If a write to the count register lands in the same cycle as the loop input, the write is applied and the decrement is dropped. This holds for a word write to code 1 and for a byte write to code 1 or code 5.
- R10: A register keeps its value when neither a write nor a decrement targets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rdAddrA | input | 3 | Register code for read port A |
| rdByteA | input | 1 | Byte mode for read port A |
| rdDataA | output | 16 | Read data, port A |
| rdAddrB | input | 3 | Register code for read port B |
| rdByteB | input | 1 | Byte mode for read port B |
| rdDataB | output | 16 | Read data, port B |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 3 | Register code for the write |
| wrByte | input | 1 | Byte mode for the write |
| wrData | input | 16 | Write data (bits 7:0 used in byte mode) |
| loopDec | input | 1 | Decrement the count register |
| loopZero | output | 1 | Count register equals 1 while loopDec is high |

## Verification
The checker assumes that the reset is held for at least one clock edge before results are judged. It also assumes that the read codes and size selects are known values at every sampled edge, so that a stable address maps to a stable register. The bench drives every input a short time after the rising edge and holds it for the whole cycle. It applies reset first, before any check. Only then does it issue writes, byte accesses, loop decrements and collisions, so every input the assertions sample is settled and defined.

// File: rtl/split_regfile_pkg.sv
package split_regfile_pkg;
  localparam int CODE_W  = 3;
  localparam int REG_NUM = 1 << CODE_W;
  localparam int GEN_W   = CODE_W - 1;
  localparam int CNT_IDX = 1;

  typedef struct packed {
    logic [REG_NUM-1:0] loEn;
    logic [REG_NUM-1:0] hiEn;
    logic               hiFromLow;
    logic               decCount;
    logic               loopReq;
  } rf_strobe_t;
endpackage

// File: rtl/split_regfile_ctrl.sv
module split_regfile_ctrl
  import split_regfile_pkg::*;
(
  input  logic              wrEn,
  input  logic [CODE_W-1:0] wrAddr,
  input  logic              wrByte,
  input  logic              loopDec,
  output rf_strobe_t        strobe
);
  logic [CODE_W-1:0] laneIdx;

  assign laneIdx = {1'b0, wrAddr[GEN_W-1:0]};

  always_comb begin
    strobe = '0;
    strobe.loopReq = loopDec;
    if (wrEn) begin
      if (wrByte) begin
        strobe.hiFromLow = 1'b1;
        if (wrAddr[CODE_W-1]) strobe.hiEn[laneIdx] = 1'b1;
        else                  strobe.loEn[laneIdx] = 1'b1;
      end else begin
        strobe.loEn[wrAddr] = 1'b1;
        strobe.hiEn[wrAddr] = 1'b1;
      end
    end
    // a normal write to the count register overrides the loop decrement
    strobe.decCount = loopDec & ~(strobe.loEn[CNT_IDX] | strobe.hiEn[CNT_IDX]);
  end
endmodule

// File: rtl/split_regfile_dp.sv
module split_regfile_dp
  import split_regfile_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PORTS  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  rf_strobe_t                    strobe,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [PORTS-1:0][CODE_W-1:0]  rdAddr,
  input  logic [PORTS-1:0]              rdByte,
  output logic [PORTS-1:0][DATA_W-1:0]  rdData,
  output logic                          loopZero
);
  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] loQ [REG_NUM];
  logic [HALF_W-1:0] hiQ [REG_NUM];
  logic [DATA_W-1:0] cntWord;
  logic [DATA_W-1:0] cntNext;
  logic [HALF_W-1:0] hiLane;

  assign cntWord  = {hiQ[CNT_IDX], loQ[CNT_IDX]};
  assign cntNext  = cntWord - DATA_W'(1);
  assign hiLane   = strobe.hiFromLow ? wrData[HALF_W-1:0] : wrData[DATA_W-1:HALF_W];
  assign loopZero = strobe.loopReq && (cntWord == DATA_W'(1));

  for (genvar r = 0; r < REG_NUM; r++) begin : g_reg
    logic decHere;
    assign decHere = (r == CNT_IDX) ? strobe.decCount : 1'b0;

    always_ff @(posedge clk) begin
      if (rst)                  loQ[r] <= '0;
      else if (strobe.loEn[r])  loQ[r] <= wrData[HALF_W-1:0];
      else if (decHere)         loQ[r] <= cntNext[HALF_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst)                  hiQ[r] <= '0;
      else if (strobe.hiEn[r])  hiQ[r] <= hiLane;
      else if (decHere)         hiQ[r] <= cntNext[DATA_W-1:HALF_W];
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [CODE_W-1:0] gen;
    assign gen = {1'b0, rdAddr[p][GEN_W-1:0]};
    always_comb begin
      if (!rdByte[p])
        rdData[p] = {hiQ[rdAddr[p]], loQ[rdAddr[p]]};
      else if (rdAddr[p][CODE_W-1])
        rdData[p] = {{HALF_W{1'b0}}, hiQ[gen]};
      else
        rdData[p] = {{HALF_W{1'b0}}, loQ[gen]};
    end
  end
endmodule

// File: rtl/split_regfile.sv
module split_regfile
  import split_regfile_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] rdAddrA,
  input  logic              rdByteA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [CODE_W-1:0] rdAddrB,
  input  logic              rdByteB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [CODE_W-1:0] wrAddr,
  input  logic              wrByte,
  input  logic [DATA_W-1:0] wrData,
  input  logic              loopDec,
  output logic              loopZero
);
  rf_strobe_t                 strobe;
  logic [1:0][DATA_W-1:0]     rdBus;

  split_regfile_ctrl ctrl_i (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrByte  (wrByte),
    .loopDec (loopDec),
    .strobe  (strobe)
  );

  split_regfile_dp #(.DATA_W(DATA_W), .PORTS(2)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .wrData   (wrData),
    .rdAddr   ({rdAddrB, rdAddrA}),
    .rdByte   ({rdByteB, rdByteA}),
    .rdData   (rdBus),
    .loopZero (loopZero)
  );

  assign rdDataA = rdBus[0];
  assign rdDataB = rdBus[1];
endmodule

// File: rtl/split_regfile_chk.sv
module split_regfile_chk
  import split_regfile_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] rdAddrA,
  input logic              rdByteA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [CODE_W-1:0] rdAddrB,
  input logic              rdByteB,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [CODE_W-1:0] wrAddr,
  input logic              wrByte,
  input logic [DATA_W-1:0] wrData,
  input logic              loopDec,
  input logic              loopZero
);
  localparam int HALF_W = DATA_W / 2;

  // R1: the cycle after a reset edge, both ports read zero
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (rdDataA == '0 && rdDataB == '0));

  // R4: byte reads carry zero in the upper byte
  assert_byte_zext_R4: assert property (@(posedge clk) disable iff (rst)
    (rdByteA |-> rdDataA[DATA_W-1:HALF_W] == '0) and
    (rdByteB |-> rdDataB[DATA_W-1:HALF_W] == '0));

  // R8: no zero indication without a loop request
  assert_zero_needs_loop_R8: assert property (@(posedge clk) disable iff (rst)
    !loopDec |-> !loopZero);

  // R8: a lone decrement lowers the count word by one
  assert_count_dec_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(loopDec && !wrEn && rdAddrB == CODE_W'(CNT_IDX) && !rdByteB)
     && rdAddrB == CODE_W'(CNT_IDX) && !rdByteB)
    |-> rdDataB == $past(rdDataB) - DATA_W'(1));

  // R10: without writes or decrements, a steady address reads steady data
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wrEn) && !$past(loopDec) &&
     $stable(rdAddrA) && $stable(rdByteA)) |-> $stable(rdDataA));
endmodule

bind split_regfile split_regfile_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/split_regfile_tb_top.sv
module split_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic        rdByteA = 1'b0, rdByteB = 1'b0, wrByte = 1'b0, wrEn = 1'b0, loopDec = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdDataA, rdDataB;
  logic        loopZero;

  int checks = 0;
  int errors = 0;
  logic [15:0] mdl [8];

  typedef struct {
    logic [15:0] expA;
    logic [15:0] expB;
    logic        expZ;
    string       tag;
  } item_t;
  item_t sbq [$];

  always #2 clk = ~clk;

  split_regfile dut_i (
    .clk(clk), .rst(rst),
    .rdAddrA(rdAddrA), .rdByteA(rdByteA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdByteB(rdByteB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrByte(wrByte), .wrData(wrData),
    .loopDec(loopDec), .loopZero(loopZero)
  );

  function automatic logic [15:0] mdlRead(input logic [2:0] a, input logic b);
    if (!b) return mdl[a];
    if (a[2]) return {8'h00, mdl[{1'b0, a[1:0]}][15:8]};
    return {8'h00, mdl[{1'b0, a[1:0]}][7:0]};
  endfunction

  // driver: one cycle of stimulus, expected results pushed to the scoreboard
  task automatic step(input logic r, input logic we, input logic [2:0] wa, input logic wb,
                      input logic [15:0] wd, input logic ld,
                      input logic [2:0] ra, input logic rab,
                      input logic [2:0] rb, input logic rbb, input string tag);
    item_t it;
    logic  cxHit;
    @(posedge clk); #1;
    rst = r; wrEn = we; wrAddr = wa; wrByte = wb; wrData = wd; loopDec = ld;
    rdAddrA = ra; rdByteA = rab; rdAddrB = rb; rdByteB = rbb;
    it.expA = mdlRead(ra, rab);
    it.expB = mdlRead(rb, rbb);
    it.expZ = ld && (mdl[1] == 16'd1);
    it.tag  = tag;
    sbq.push_back(it);
    cxHit = we && (wb ? (wa[1:0] == 2'd1) : (wa == 3'd1));
    if (r) begin
      for (int i = 0; i < 8; i++) mdl[i] = '0;
    end else begin
      if (ld && !cxHit) mdl[1] = mdl[1] - 16'd1;
      if (we) begin
        if (!wb) mdl[wa] = wd;
        else if (wa[2]) mdl[{1'b0, wa[1:0]}][15:8] = wd[7:0];
        else mdl[{1'b0, wa[1:0]}][7:0] = wd[7:0];
      end
    end
  endtask

  task automatic rd(input logic [2:0] ra, input logic rab, input logic [2:0] rb,
                    input logic rbb, input string tag);
    step(1'b0, 1'b0, 3'd0, 1'b0, 16'h0, 1'b0, ra, rab, rb, rbb, tag);
  endtask

  task automatic wr(input logic [2:0] wa, input logic wb, input logic [15:0] wd, input string tag);
    step(1'b0, 1'b1, wa, wb, wd, 1'b0, wa, wb, 3'd1, 1'b0, tag);
  endtask

  // monitor: pops one item per cycle, samples mid-cycle
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks += 3;
      if (rdDataA !== it.expA) begin
        errors++;
        $display("FAIL %s port A: actual %h expected %h", it.tag, rdDataA, it.expA);
      end
      if (rdDataB !== it.expB) begin
        errors++;
        $display("FAIL %s port B: actual %h expected %h", it.tag, rdDataB, it.expB);
      end
      if (loopZero !== it.expZ) begin
        errors++;
        $display("FAIL %s loopZero: actual %b expected %b", it.tag, loopZero, it.expZ);
      end
    end
  end

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state on every code
    for (int i = 0; i < 8; i++) rd(3'(i), 1'b0, 3'(7 - i), 1'b0, "R1 after reset");
    // R2 word writes to all eight codes, then read back
    for (int i = 0; i < 8; i++) wr(3'(i), 1'b0, 16'h1234 + 16'(i) * 16'h1111, "R2 word write");
    for (int i = 0; i < 8; i++) rd(3'(i), 1'b0, 3'((i + 3) % 8), 1'b0, "R2 R7 word read");
    // R3 byte writes keep the other half
    wr(3'd0, 1'b1, 16'hEE5A, "R3 low byte write");
    wr(3'd4, 1'b1, 16'h77C3, "R3 high byte write");
    wr(3'd7, 1'b1, 16'h0099, "R3 high byte write base");
    wr(3'd2, 1'b1, 16'hFF01, "R3 low byte write data");
    for (int i = 0; i < 4; i++) rd(3'(i), 1'b0, 3'(i), 1'b1, "R3 R4 word vs low byte");
    // R4 high byte reads, zero extended
    for (int i = 4; i < 8; i++) rd(3'(i), 1'b1, 3'(i - 4), 1'b0, "R4 high byte read");
    // R5 byte writes with codes 4..7 leave pointer registers alone
    for (int i = 4; i < 8; i++) wr(3'(i), 1'b1, 16'hA5A5, "R5 byte write code");
    for (int i = 4; i < 8; i++) rd(3'(i), 1'b0, 3'(i - 4), 1'b0, "R5 pointer unchanged");
    // R6 read during write returns old value
    step(1'b0, 1'b1, 3'd5, 1'b0, 16'hBEEF, 1'b0, 3'd5, 1'b0, 3'd5, 1'b0, "R6 same-cycle read");
    step(1'b0, 1'b1, 3'd6, 1'b1, 16'h0011, 1'b0, 3'd6, 1'b1, 3'd2, 1'b0, "R6 byte same-cycle");
    rd(3'd5, 1'b0, 3'd6, 1'b1, "R6 after write");
    // R8 countdown to zero
    wr(3'd1, 1'b0, 16'd3, "R8 load count");
    for (int i = 0; i < 4; i++)
      step(1'b0, 1'b0, 3'd0, 1'b0, 16'h0, 1'b1, 3'd0, 1'b0, 3'd1, 1'b0, "R8 decrement");
    rd(3'd1, 1'b0, 3'd5, 1'b1, "R8 wrapped count");
    // R9 write beats decrement
    step(1'b0, 1'b1, 3'd1, 1'b0, 16'h0001, 1'b1, 3'd1, 1'b0, 3'd1, 1'b0, "R9 word write vs dec");
    rd(3'd1, 1'b0, 3'd1, 1'b1, "R9 word write won");
    step(1'b0, 1'b1, 3'd5, 1'b1, 16'h0042, 1'b1, 3'd1, 1'b0, 3'd5, 1'b1, "R9 high byte vs dec");
    step(1'b0, 1'b1, 3'd1, 1'b1, 16'h0007, 1'b1, 3'd1, 1'b0, 3'd1, 1'b1, "R9 low byte vs dec");
    rd(3'd1, 1'b0, 3'd5, 1'b1, "R9 byte write won");
    // R8 decrement with a write elsewhere still decrements
    step(1'b0, 1'b1, 3'd3, 1'b0, 16'h5555, 1'b1, 3'd1, 1'b0, 3'd3, 1'b0, "R8 dec with other write");
    rd(3'd1, 1'b0, 3'd3, 1'b0, "R8 dec applied");
    // R10 idle cycles hold state
    for (int i = 0; i < 8; i++) rd(3'(i), 1'b0, 3'(i), 1'b0, "R10 hold");
    // R1 reset again clears everything
    step(1'b1, 1'b0, 3'd0, 1'b0, 16'h0, 1'b0, 3'd0, 1'b0, 3'd4, 1'b0, "R1 reset cycle");
    for (int i = 0; i < 8; i++) rd(3'(i), 1'b0, 3'(i), 1'b1, "R1 cleared");
    @(posedge clk);
    @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule